// File: doc/BRIEF.md
# Dual-Lane Word Multiplier with Fractional Saturation

This block splits each of two 64-bit operands into an upper and a lower 32-bit word. It multiplies the upper words together and the lower words together, in parallel. Each lane forms a full 64-bit product, read as a signed fraction, a signed integer or an unsigned integer. One mode bit decides, for both lanes at once, whether the upper or the lower half of each product is returned. The two returned words are packed into a 64-bit result, with the upper lane on top.

In fractional form, only the square of the most negative word can overflow. With saturation enabled, that lane is clamped to the value set by the half being returned. Each lane also raises its own overflow flag, and a write strobe tells the status register to record both flags. Without saturation the product wraps and the status register is left alone. When the accumulate control is set, the whole 64-bit result is also copied into the block's accumulator. The block takes a new operation every cycle, and each result appears two cycles after it is issued.

Top module: `dual_word_mul`

## Requirements
- R1: The upper lane multiplies `op_a[63:32]` by `op_b[63:32]` and the lower lane multiplies `op_a[31:0]` by `op_b[31:0]`. The upper lane's word lands in `result[63:32]` and the lower lane's word in `result[31:0]`.
- R2: With `take_high`=1 each lane returns bits 63:32 of its 64-bit product. With `take_high`=0 it returns bits 31:0. The choice applies to both lanes.
- R3: With `mul_kind`=2'b00 (signed fractional) the product is the signed product shifted left by one bit, kept to 64 bits. Without saturation, 0x80000000 times 0x80000000 wraps to 0x8000000000000000 and no overflow is reported.
- R4: With signed fractional, `saturate`=1 and `take_high`=1, a lane whose operands are both 0x80000000 returns 0x7fffffff.
- R5: With signed fractional, `saturate`=1 and `take_high`=0, a lane whose operands are both 0x80000000 returns 0xffffffff.
- R6: `stat_we` is 1 with a result exactly when that operation was signed fractional with `saturate`=1. `lane_ovf[1]` (upper lane) and `lane_ovf[0]` (lower lane) then show each lane's overflow. In every other case both `stat_we` and `lane_ovf` are 0.
- R7: With `mul_kind`=2'b01 the product is the exact signed 64-bit product of the two words.
- R8: With `mul_kind`=2'b10 the product is the exact unsigned 64-bit product. The code 2'b11 behaves the same way.
- R9: When an operation has `acc_write`=1, `acc_value` equals its `result` from the cycle that result appears. Otherwise `acc_value` holds its value.
- R10: An operation presented with `in_valid`=1 at a clock edge produces `out_valid`=1 and its result exactly two edges later. One operation per cycle is accepted with no gaps needed.
- R11: While `rst_n`=0, `out_valid`, `result`, `acc_value`, `stat_we` and `lane_ovf` are all 0.
- R12: In the integer modes `saturate` has no effect. Results are unclamped and `stat_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 64 | First operand, two words |
| op_b | input | 64 | Second operand, two words |
| mul_kind | input | 2 | 00 signed fractional, 01 signed integer, 10/11 unsigned integer |
| take_high | input | 1 | 1 returns product bits 63:32, 0 returns bits 31:0 |
| saturate | input | 1 | Clamp fractional overflow and report it |
| acc_write | input | 1 | Copy the result into the accumulator |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed lane words |
| acc_value | output | 64 | Accumulator contents |
| stat_we | output | 1 | Status register should record `lane_ovf` |
| lane_ovf | output | 2 | Overflow per lane, bit 1 upper, bit 0 lower |

## Verification
A bad stage-one product shows up in `result` two cycles after the operation is issued. A stale mode bit shows at the same point, as the wrong half being returned or a missed clamp. A wrongly gated overflow appears at once as `stat_we` or `lane_ovf` being set when they should be clear, or clear when they should be set. An accumulator that loaded when it should not, or missed a load, stays wrong. It is therefore caught at the next compared result, because every result is checked against the accumulator the model expects.

// File: rtl/dual_word_mul_pkg.sv
package dual_word_mul_pkg;
  typedef enum logic [1:0] {
    MK_SFRAC = 2'b00,
    MK_SINT  = 2'b01,
    MK_UINT  = 2'b10,
    MK_UALT  = 2'b11
  } mul_kind_e;
endpackage

// File: rtl/dwm_lane_mult.sv
module dwm_lane_mult
  import dual_word_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [1:0]      kind,
  output logic [2*W-1:0]  prod_q,
  output logic            frac_ovf_q
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  MOST_NEG  = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] WRAP_PROD = {1'b1, {(PW-1){1'b0}}};

  function automatic logic [PW-1:0] widen(input logic [W-1:0] x, input logic sgn);
    return sgn ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
  endfunction

  function automatic logic [PW-1:0] lane_product(input logic [W-1:0] x, input logic [W-1:0] y,
                                                  input logic [1:0] k);
    logic          sgn;
    logic [PW-1:0] p;
    sgn = (k == MK_SFRAC) || (k == MK_SINT);
    p   = widen(x, sgn) * widen(y, sgn);
    if (k == MK_SFRAC) p = {p[PW-2:0], 1'b0};
    return p;
  endfunction

  logic            min_square;
  logic [PW-1:0]   prod_d;

  assign min_square = (kind == MK_SFRAC) && (a == MOST_NEG) && (b == MOST_NEG);
  assign prod_d     = lane_product(a, b, kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q     <= '0;
      frac_ovf_q <= 1'b0;
    end else begin
      frac_ovf_q <= en && min_square;
      if (en) prod_q <= prod_d;
    end
  end

  // R3: an overflow flag only follows a fractional square of the most negative word
  a_r3_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    frac_ovf_q |-> $past(en && kind == MK_SFRAC && a == MOST_NEG && b == MOST_NEG));

  // R3: that case wraps to the top bit alone
  a_r3_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
    frac_ovf_q |-> prod_q == WRAP_PROD);
endmodule

// File: rtl/dwm_word_pick.sv
module dwm_word_pick #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic           frac_ovf,
  input  logic           sat_en,
  input  logic           sel_high,
  output logic [W-1:0]   word,
  output logic           sat_hit
);
  localparam logic [W-1:0] CLAMP_HI = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] CLAMP_LO = {W{1'b1}};

  function automatic logic [W-1:0] pick(input logic [2*W-1:0] p, input logic hi,
                                        input logic clamp);
    if (clamp) return hi ? CLAMP_HI : CLAMP_LO;
    return hi ? p[2*W-1:W] : p[W-1:0];
  endfunction

  assign sat_hit = frac_ovf && sat_en;
  assign word    = pick(prod, sel_high, sat_hit);
endmodule

// File: rtl/dual_word_mul.sv
module dual_word_mul
  import dual_word_mul_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANE_W*LANES-1:0]  op_a,
  input  logic [LANE_W*LANES-1:0]  op_b,
  input  logic [1:0]               mul_kind,
  input  logic                     take_high,
  input  logic                     saturate,
  input  logic                     acc_write,
  output logic                     out_valid,
  output logic [LANE_W*LANES-1:0]  result,
  output logic [LANE_W*LANES-1:0]  acc_value,
  output logic                     stat_we,
  output logic [LANES-1:0]         lane_ovf
);
  localparam int DW = LANE_W * LANES;
  localparam int PW = 2 * LANE_W;

  // stage one: operation controls travelling with the products
  logic s1_valid, s1_high, s1_sat, s1_accw;
  // stage two: controls kept alongside the result for checking
  logic s2_high, s2_accw;

  logic [DW-1:0]    packed_word;
  logic [LANES-1:0] lane_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_high  <= 1'b0;
      s1_sat   <= 1'b0;
      s1_accw  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_high <= take_high;
        s1_sat  <= saturate && (mul_kind == MK_SFRAC);
        s1_accw <= acc_write;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PW-1:0] prod;
    logic          ovf;

    dwm_lane_mult #(.W(LANE_W)) u_mult (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (in_valid),
      .a          (op_a[l*LANE_W +: LANE_W]),
      .b          (op_b[l*LANE_W +: LANE_W]),
      .kind       (mul_kind),
      .prod_q     (prod),
      .frac_ovf_q (ovf)
    );

    dwm_word_pick #(.W(LANE_W)) u_pick (
      .prod     (prod),
      .frac_ovf (ovf),
      .sat_en   (s1_sat),
      .sel_high (s1_high),
      .word     (packed_word[l*LANE_W +: LANE_W]),
      .sat_hit  (lane_hit[l])
    );

    // R4: a flagged lane returning the upper half is clamped to the largest positive word
    a_r4_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && stat_we && s2_high && lane_ovf[l]) |->
        result[l*LANE_W +: LANE_W] == {1'b0, {(LANE_W-1){1'b1}}});

    // R5: a flagged lane returning the lower half is clamped to all ones
    a_r5_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && stat_we && !s2_high && lane_ovf[l]) |->
        result[l*LANE_W +: LANE_W] == {LANE_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      acc_value <= '0;
      stat_we   <= 1'b0;
      lane_ovf  <= '0;
      s2_high   <= 1'b0;
      s2_accw   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      stat_we   <= s1_valid && s1_sat;
      lane_ovf  <= s1_valid ? lane_hit : '0;
      if (s1_valid) begin
        result  <= packed_word;
        s2_high <= s1_high;
        s2_accw <= s1_accw;
        if (s1_accw) acc_value <= packed_word;
      end
    end
  end

  // R10: two-edge latency from issue to result
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(in_valid, 2)) |-> out_valid);

  // R6: overflow flags never show without a status write
  a_r6_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |-> lane_ovf == '0);

  // R9: an accumulating result is mirrored in the accumulator
  a_r9_acc_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s2_accw) |-> acc_value == result);

  // R9: the accumulator holds when no accumulating result is written
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(s1_valid && s1_accw) |=> $stable(acc_value));
endmodule

// File: tb/dual_word_mul_bench.sv
module dual_word_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic [1:0]  mul_kind;
  logic        take_high, saturate, acc_write;
  logic        out_valid;
  logic [63:0] result, acc_value;
  logic        stat_we;
  logic [1:0]  lane_ovf;

  always #5 clk = ~clk;

  dual_word_mul u_dual_word_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mul_kind(mul_kind), .take_high(take_high), .saturate(saturate),
    .acc_write(acc_write), .out_valid(out_valid), .result(result),
    .acc_value(acc_value), .stat_we(stat_we), .lane_ovf(lane_ovf)
  );

  typedef struct {
    logic [63:0] dest;
    logic [63:0] acc;
    logic        we;
    logic [1:0]  ovf;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [63:0] model_acc = '0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // independent model of one lane word
  function automatic logic [31:0] model_word(input logic [31:0] a, input logic [31:0] b,
      input logic [1:0] k, input logic hi, input logic sat, output logic ov);
    longint      sp;
    logic [63:0] p;
    ov = 1'b0;
    sp = longint'($signed(a)) * longint'($signed(b));
    if (k == 2'd0) begin
      p  = 64'(sp * 2);
      ov = sat && a == 32'h8000_0000 && b == 32'h8000_0000;
    end else if (k == 2'd1) p = 64'(sp);
    else p = {32'h0, a} * {32'h0, b};
    if (ov) return hi ? 32'h7fff_ffff : 32'hffff_ffff;
    return hi ? p[63:32] : p[31:0];
  endfunction

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] k,
                       input logic hi, input logic sat, input logic accw, input string tag);
    exp_t e;
    logic oh, ol;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; mul_kind = k;
    take_high = hi; saturate = sat; acc_write = accw;
    e.dest = {model_word(a[63:32], b[63:32], k, hi, sat, oh),
              model_word(a[31:0], b[31:0], k, hi, sat, ol)};
    if (accw) model_acc = e.dest;
    e.acc = model_acc;
    e.we  = sat && k == 2'd0;
    e.ovf = {oh, ol};
    e.due = cyc + 2;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 64'hdead_beef_0bad_f00d;
      acc_write = 1'b1;
    end
  endtask

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (sb.size() == 0) check(0, "R10 unexpected out_valid", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, {e.tag, " R10 latency"}, 64'(cyc), 64'(e.due));
        check(result === e.dest, {e.tag, " result"}, result, e.dest);
        check(acc_value === e.acc, {e.tag, " R9 acc_value"}, acc_value, e.acc);
        check({stat_we, lane_ovf} === {e.we, e.ovf}, {e.tag, " R6 stat_we/lane_ovf"},
              64'({stat_we, lane_ovf}), 64'({e.we, e.ovf}));
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; mul_kind = 2'd0;
    take_high = 1'b0; saturate = 1'b0; acc_write = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0 && result === '0 && acc_value === '0 && stat_we === 1'b0 &&
          lane_ovf === 2'b00, "R11 reset state", result | acc_value, 64'd0);
    rst_n = 1'b1;

    // R1 R7: signed integer, lanes kept apart, lower half
    issue({32'd3, 32'hffff_fffb}, {32'd7, 32'd9}, 2'd1, 1'b0, 1'b0, 1'b0, "R1 R7 lanes");
    // R2: upper half of a large signed product
    issue({32'h4000_0000, 32'hc000_0000}, {32'h4000_0000, 32'h4000_0000}, 2'd1, 1'b1, 1'b0,
          1'b0, "R2 high half");
    // R8: unsigned, both halves and the alternate code
    issue({2{32'hffff_ffff}}, {2{32'hffff_ffff}}, 2'd2, 1'b1, 1'b0, 1'b1, "R8 uint high");
    issue({2{32'hffff_ffff}}, {32'h0000_0002, 32'hffff_ffff}, 2'd3, 1'b0, 1'b0, 1'b0,
          "R8 alt code low");
    // R3: fractional, ordinary and wrapping most-negative square
    issue({32'h4000_0000, 32'h8000_0000}, {32'h4000_0000, 32'h8000_0000}, 2'd0, 1'b1, 1'b0,
          1'b1, "R3 frac wrap high");
    issue({2{32'h8000_0000}}, {2{32'h8000_0000}}, 2'd0, 1'b0, 1'b0, 1'b0, "R3 frac wrap low");
    idle(2);
    // R4 R6: saturation on the lower lane only, upper half
    issue({32'h6000_0000, 32'h8000_0000}, {32'hb000_0000, 32'h8000_0000}, 2'd0, 1'b1, 1'b1,
          1'b0, "R4 R6 clamp high");
    // R5 R6: saturation on the upper lane only, lower half
    issue({32'h8000_0000, 32'h1234_5678}, {32'h8000_0000, 32'h8000_0000}, 2'd0, 1'b0, 1'b1,
          1'b1, "R5 R6 clamp low");
    // R4 R5: both lanes clamped
    issue({2{32'h8000_0000}}, {2{32'h8000_0000}}, 2'd0, 1'b1, 1'b1, 1'b0, "R4 both lanes");
    // R6: saturating with no overflow still writes status with clear flags
    issue({32'h4000_0000, 32'h0000_0001}, {32'h2000_0000, 32'hffff_ffff}, 2'd0, 1'b1, 1'b1,
          1'b0, "R6 no overflow");
    // R12: saturate in integer modes does nothing
    issue({2{32'h8000_0000}}, {2{32'h8000_0000}}, 2'd1, 1'b1, 1'b1, 1'b0, "R12 sint");
    issue({2{32'h8000_0000}}, {2{32'h8000_0000}}, 2'd2, 1'b0, 1'b1, 1'b1, "R12 uint");
    idle(1);
    // R9 R10: back-to-back mixed stream
    for (int i = 0; i < 40; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 7 == 0) begin ra[31:0] = 32'h8000_0000; rb[31:0] = 32'h8000_0000; end
      issue(ra, rb, 2'(i % 4), 1'(i % 3 == 0), 1'(i % 2), 1'(i % 5 == 0), "R9 R10 stream");
    end
    idle(4);
    check(sb.size() == 0, "R10 results outstanding", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule